// File: doc/BRIEF.md
# Trace Buffer Sequencer Controller

The controller captures selected bus cycles into a circular trace memory of 64 entries. A small four-state sequencer, advanced by trigger pulses from external comparators, decides when the capture window is open. Reaching the last sequencer state is the trace trigger. The alignment setting places the stored window relative to that trigger: after it (begin), before it (end), or around it (mid).

The capture mode sets which bus cycles are kept:
- **flow mode** keeps change-of-flow cycles only.
- **loop mode** does the same, but skips an entry whose address repeats the one most recently stored.
- **detail mode** keeps every valid cycle except free cycles and opcode fetches.

Software arms the block, waits for the done flag, and then reads the entries back oldest first through an index port.

The capture window is run by a recording machine with four states:
- **REC_IDLE**: after reset.
- **REC_PRE**: armed, trigger not yet seen.
- **REC_POST**: trigger seen, still capturing.
- **REC_DONE**: capture finished.

Its transitions are:
- **arm**: any state goes to REC_PRE.
- **hit-to-post**: REC_PRE goes to REC_POST for begin or mid alignment.
- **hit-to-done**: REC_PRE goes to REC_DONE for end alignment.
- **fill-to-done**: REC_POST goes to REC_DONE on the last store.

The sequencer has states SEQ_S1, SEQ_S2, SEQ_S3 and SEQ_FINAL. It has one table-driven transition, **advance**, and one reset transition, **restart**, taken on arm.

Top module: `trace_seq_ctrl`

## Requirements
- R1: After reset `done` is 0, `count` is 0 and `rd_data` is 0.
- R2: A cycle with `arm` high stores nothing. At the next edge it clears `count` and `done`, puts the sequencer in state 1, forgets the last stored address, and enters capture.
- R3: The table has one 4-bit entry per state for states 1..3, with state k (k = 0, 1, 2) at bits [4k+3:4k].
  - Bits [1:0] of an entry select the trigger input.
  - Bits [3:2] give the next state: 0 to 2 mean states 1 to 3, and 3 means final.
  - While capture is armed and the trigger has not been reached, the state changes only in a cycle where the selected trigger bit is 1.
- R4: With `cfg_mode`=0 (flow), a cycle is stored only if `bus_valid` and `bus_cof` are both 1. Each entry is {`bus_addr`, `bus_data`}, with the address in the upper bits.
- R5: With `cfg_mode`=1 (loop), the rule of R4 applies. In addition, a cycle whose address equals the most recently stored address since arm is dropped.
- R6: With `cfg_mode`=2 (detail), every cycle with `bus_valid` is stored unless `bus_free` or `bus_opfetch` is 1.
- R7: With `cfg_mode`=3, nothing is stored.
- R8: With `cfg_align`=0 (begin), nothing is stored before the trigger. Storing starts in the cycle after the trigger is reached. `done` rises at the edge that stores the 64th entry.
- R9: With `cfg_align`=2 or 3 (end), cycles up to and including the trigger cycle are stored. `done` rises at the edge where the trigger is reached.
- R10: With `cfg_align`=1 (mid), storing runs before the trigger. It continues after the trigger until 32 more entries have been stored, and then `done` rises.
- R11: `count` is the number of stored entries, saturating at 64. Older entries are overwritten once the buffer is full. `rd_idx`=0 reads the oldest retained entry.
- R12: `rd_data` is 0 whenever `done` is 0, and also whenever `rd_idx` is not below `count`.
- R13: Once `done` is 1, and until the next arm, nothing is stored and trigger inputs have no effect on `count` or `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | Restart capture (one-cycle pulse) |
| cfg_mode | input | 2 | Capture mode: 0 flow, 1 loop, 2 detail, 3 off |
| cfg_align | input | 2 | Window alignment: 0 begin, 1 mid, 2/3 end |
| cfg_seq_tbl | input | 12 | Sequencer transition table (see R3) |
| trig | input | 4 | Comparator trigger pulses |
| bus_valid | input | 1 | Bus cycle present |
| bus_addr | input | 16 | Bus cycle address |
| bus_data | input | 16 | Bus cycle data |
| bus_cof | input | 1 | Cycle is a change of flow |
| bus_free | input | 1 | Cycle is a free cycle |
| bus_opfetch | input | 1 | Cycle is an opcode fetch |
| rd_idx | input | 6 | Read index, 0 = oldest |
| rd_data | output | 32 | Entry {address, data} |
| count | output | 7 | Stored entry count, 0..64 |
| done | output | 1 | Capture finished |

## Verification
The bench targets a trigger pulse on a trigger input the current state does not select. A design that ignored the table would finish early. It targets loop capture drawn from only four addresses, where a design comparing against the last seen cycle instead of the last stored one keeps or drops the wrong entries. A mid-aligned run wraps the buffer well before the trigger. A design with a wrong oldest-entry mapping or half-depth stop returns the entries rotated or stops at the wrong count. The bench also re-arms during capture and drives traffic after completion, where a leaky design keeps counting.

// File: rtl/trace_seq_pkg.sv
package trace_seq_pkg;

    typedef enum logic [1:0] {
        SEQ_S1    = 2'd0,
        SEQ_S2    = 2'd1,
        SEQ_S3    = 2'd2,
        SEQ_FINAL = 2'd3
    } seq_state_e;

    typedef enum logic [1:0] {
        REC_IDLE = 2'd0,
        REC_PRE  = 2'd1,
        REC_POST = 2'd2,
        REC_DONE = 2'd3
    } rec_state_e;

    typedef enum logic [1:0] {
        CAP_FLOW   = 2'd0,
        CAP_LOOP   = 2'd1,
        CAP_DETAIL = 2'd2,
        CAP_OFF    = 2'd3
    } cap_mode_e;

    typedef enum logic [1:0] {
        ALN_BEGIN = 2'd0,
        ALN_MID   = 2'd1,
        ALN_END   = 2'd2,
        ALN_END2  = 2'd3
    } align_e;

endpackage

// File: rtl/trace_seq_sequencer.sv
module trace_seq_sequencer
    import trace_seq_pkg::*;
#(
    parameter int NTRIG = 4,
    parameter int SEL_W = 2,
    localparam int ENT_W = SEL_W + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 restart,
    input  logic                 active,
    input  logic [NTRIG-1:0]     trig,
    input  logic [3*ENT_W-1:0]   tbl,
    output seq_state_e           state,
    output logic                 hit
);

    logic [SEL_W-1:0] sel_arr [4];
    seq_state_e       nxt_arr [4];

    for (genvar k = 0; k < 3; k++) begin : g_entry
        assign sel_arr[k] = tbl[k*ENT_W +: SEL_W];
        assign nxt_arr[k] = seq_state_e'(tbl[k*ENT_W + SEL_W +: 2]);
    end
    assign sel_arr[3] = '0;
    assign nxt_arr[3] = SEQ_FINAL;

    logic fire;
    assign fire = active && (state != SEQ_FINAL) && trig[sel_arr[state]];
    assign hit  = fire && (nxt_arr[state] == SEQ_FINAL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       state <= SEQ_S1;
        else if (restart) state <= SEQ_S1;
        else if (fire)    state <= nxt_arr[state];
    end

endmodule

// File: rtl/trace_seq_filter.sv
module trace_seq_filter
    import trace_seq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  cap_mode_e         mode,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_cof,
    input  logic              bus_free,
    input  logic              bus_opfetch,
    input  logic              commit,
    output logic              qualify
);

    logic [ADDR_W-1:0] last_addr;
    logic              have_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_addr <= '0;
            have_last <= 1'b0;
        end else if (restart) begin
            have_last <= 1'b0;
        end else if (commit) begin
            last_addr <= bus_addr;
            have_last <= 1'b1;
        end
    end

    always_comb begin
        unique case (mode)
            CAP_FLOW:   qualify = bus_valid && bus_cof;
            CAP_LOOP:   qualify = bus_valid && bus_cof &&
                                  !(have_last && (bus_addr == last_addr));
            CAP_DETAIL: qualify = bus_valid && !bus_free && !bus_opfetch;
            CAP_OFF:    qualify = 1'b0;
        endcase
    end

endmodule

// File: rtl/trace_seq_buf.sv
module trace_seq_buf #(
    parameter int W     = 32,
    parameter int DEPTH = 64,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             we,
    input  logic [W-1:0]     wdata,
    input  logic             visible,
    input  logic [PTR_W-1:0] rd_idx,
    output logic [CNT_W-1:0] count,
    output logic [W-1:0]     rd_data
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wptr;
    logic [PTR_W-1:0] phys;

    always_ff @(posedge clk) begin
        if (we) mem[wptr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            count <= '0;
        end else if (restart) begin
            wptr  <= '0;
            count <= '0;
        end else if (we) begin
            wptr  <= wptr + PTR_W'(1);
            count <= (count == FULL) ? count : count + CNT_W'(1);
        end
    end

    assign phys    = (count == FULL) ? (wptr + rd_idx) : rd_idx;
    assign rd_data = (visible && ({1'b0, rd_idx} < count)) ? mem[phys] : '0;

endmodule

// File: rtl/trace_seq_ctrl.sv
module trace_seq_ctrl
    import trace_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int DEPTH  = 64,
    parameter int NTRIG  = 4,
    localparam int PTR_W   = $clog2(DEPTH),
    localparam int CNT_W   = PTR_W + 1,
    localparam int SEL_W   = (NTRIG > 1) ? $clog2(NTRIG) : 1,
    localparam int TBL_W   = 3 * (SEL_W + 2),
    localparam int ENTRY_W = ADDR_W + DATA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               arm,
    input  logic [1:0]         cfg_mode,
    input  logic [1:0]         cfg_align,
    input  logic [TBL_W-1:0]   cfg_seq_tbl,
    input  logic [NTRIG-1:0]   trig,
    input  logic               bus_valid,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_data,
    input  logic               bus_cof,
    input  logic               bus_free,
    input  logic               bus_opfetch,
    input  logic [PTR_W-1:0]   rd_idx,
    output logic [ENTRY_W-1:0] rd_data,
    output logic [CNT_W-1:0]   count,
    output logic               done
);

    localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(DEPTH - 1);
    localparam logic [PTR_W-1:0] HALF_LAST = PTR_W'(DEPTH / 2 - 1);

    rec_state_e rec_q, rec_nxt;
    seq_state_e seq_q;
    align_e     aln;
    logic       seq_hit, seq_run, rec_en, qualify, wr_en;
    logic [PTR_W-1:0] post_q;

    assign aln   = align_e'(cfg_align);
    assign wr_en = qualify && rec_en && !arm;

    trace_seq_sequencer #(.NTRIG(NTRIG), .SEL_W(SEL_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (arm),
        .active  (seq_run),
        .trig    (trig),
        .tbl     (cfg_seq_tbl),
        .state   (seq_q),
        .hit     (seq_hit)
    );

    trace_seq_filter #(.ADDR_W(ADDR_W)) u_filt (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart     (arm),
        .mode        (cap_mode_e'(cfg_mode)),
        .bus_valid   (bus_valid),
        .bus_addr    (bus_addr),
        .bus_cof     (bus_cof),
        .bus_free    (bus_free),
        .bus_opfetch (bus_opfetch),
        .commit      (wr_en),
        .qualify     (qualify)
    );

    trace_seq_buf #(.W(ENTRY_W), .DEPTH(DEPTH)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (arm),
        .we      (wr_en),
        .wdata   ({bus_addr, bus_data}),
        .visible (done),
        .rd_idx  (rd_idx),
        .count   (count),
        .rd_data (rd_data)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rec_q <= REC_IDLE;
        else        rec_q <= rec_nxt;
    end

    // Entries stored after the trigger (mid alignment)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          post_q <= '0;
        else if (arm)                        post_q <= '0;
        else if (wr_en && rec_q == REC_POST) post_q <= post_q + PTR_W'(1);
    end

    // Next state
    always_comb begin
        rec_nxt = rec_q;
        unique case (rec_q)
            REC_IDLE: rec_nxt = REC_IDLE;
            REC_PRE: begin
                if (seq_hit)
                    rec_nxt = (aln == ALN_BEGIN || aln == ALN_MID) ? REC_POST : REC_DONE;
            end
            REC_POST: begin
                if (wr_en && ((aln == ALN_BEGIN && count == LAST_SLOT) ||
                              (aln == ALN_MID   && post_q == HALF_LAST)))
                    rec_nxt = REC_DONE;
            end
            REC_DONE: rec_nxt = REC_DONE;
        endcase
        if (arm) rec_nxt = REC_PRE;
    end

    // Outputs
    always_comb begin
        rec_en  = 1'b0;
        seq_run = 1'b0;
        done    = 1'b0;
        unique case (rec_q)
            REC_IDLE: ;
            REC_PRE: begin
                rec_en  = (aln != ALN_BEGIN);
                seq_run = !arm;
            end
            REC_POST: rec_en = 1'b1;
            REC_DONE: done   = 1'b1;
        endcase
    end

endmodule

// File: rtl/trace_seq_chk.sv
module trace_seq_chk #(
    parameter int DEPTH   = 64,
    parameter int CNT_W   = 7,
    parameter int ENTRY_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               arm,
    input logic [1:0]         cfg_mode,
    input logic               bus_valid,
    input logic               bus_cof,
    input logic               bus_free,
    input logic               bus_opfetch,
    input logic [ENTRY_W-1:0] rd_data,
    input logic [CNT_W-1:0]   count,
    input logic               done
);

    assert_arm_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (count == '0 && !done));

    assert_flow_skips_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'd0 && !bus_cof && !arm) |=> (count == $past(count)));

    assert_detail_skips_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'd2 && bus_valid && (bus_free || bus_opfetch) && !arm)
        |=> (count == $past(count)));

    assert_off_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'd3 && !arm) |=> (count == $past(count)));

    assert_count_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    assert_count_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |=> (count == $past(count) || count == $past(count) + CNT_W'(1)));

    assert_read_masked_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (rd_data == '0));

    assert_done_sticky_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !arm) |=> done);

    assert_count_frozen_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !arm) |=> $stable(count));

endmodule

bind trace_seq_ctrl trace_seq_chk #(
    .DEPTH   (DEPTH),
    .CNT_W   (CNT_W),
    .ENTRY_W (ENTRY_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .arm         (arm),
    .cfg_mode    (cfg_mode),
    .bus_valid   (bus_valid),
    .bus_cof     (bus_cof),
    .bus_free    (bus_free),
    .bus_opfetch (bus_opfetch),
    .rd_data     (rd_data),
    .count       (count),
    .done        (done)
);

// File: tb/trace_seq_ctrl_tb.sv
module trace_seq_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arm = 1'b0;
    logic [1:0]  cfg_mode = 2'd0;
    logic [1:0]  cfg_align = 2'd0;
    logic [11:0] cfg_seq_tbl = 12'h0;
    logic [3:0]  trig = 4'h0;
    logic        bus_valid = 1'b0;
    logic [15:0] bus_addr = 16'h0;
    logic [15:0] bus_data = 16'h0;
    logic        bus_cof = 1'b0;
    logic        bus_free = 1'b0;
    logic        bus_opfetch = 1'b0;
    logic [5:0]  rd_idx = 6'd0;
    logic [31:0] rd_data;
    logic [6:0]  count;
    logic        done;

    always #2 clk = ~clk;

    trace_seq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .arm(arm), .cfg_mode(cfg_mode),
        .cfg_align(cfg_align), .cfg_seq_tbl(cfg_seq_tbl), .trig(trig),
        .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_data(bus_data),
        .bus_cof(bus_cof), .bus_free(bus_free), .bus_opfetch(bus_opfetch),
        .rd_idx(rd_idx), .rd_data(rd_data), .count(count), .done(done)
    );

    int n_cmp = 0;
    int n_bad = 0;
    string cur_tag = "R9";

    // Reference model state
    int          m_ph = 0;      // 0 idle, 1 pre, 2 post, 3 done
    int          m_seq = 0;
    logic [31:0] m_q[$];
    logic [15:0] m_last = 16'h0;
    bit          m_have = 0;
    int          m_post = 0;

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_step(input logic a, input logic v, input logic [15:0] ad,
                              input logic [15:0] dt, input logic cof, input logic fr,
                              input logic op, input logic [3:0] tr);
        bit ok, allow, hit, st;
        int src, nxt;
        if (a) begin
            m_ph = 1; m_seq = 0; m_q.delete(); m_have = 0; m_post = 0;
            return;
        end
        case (cfg_mode)
            2'd0: ok = v && cof;
            2'd1: ok = v && cof && !(m_have && ad == m_last);
            2'd2: ok = v && !fr && !op;
            default: ok = 0;
        endcase
        allow = (m_ph == 1 && cfg_align != 2'd0) || m_ph == 2;
        hit = 0;
        if (m_ph == 1) begin
            src = int'(cfg_seq_tbl[m_seq*4 +: 2]);
            nxt = int'(cfg_seq_tbl[m_seq*4+2 +: 2]);
            if (tr[src]) begin
                hit = (nxt == 3);
                m_seq = nxt;
            end
        end
        st = ok && allow;
        if (st) begin
            m_q.push_back({ad, dt});
            if (m_q.size() > 64) void'(m_q.pop_front());
            m_last = ad; m_have = 1;
            if (m_ph == 2) m_post++;
        end
        if (m_ph == 1 && hit)
            m_ph = (cfg_align >= 2'd2) ? 3 : 2;
        else if (m_ph == 2 && st &&
                 ((cfg_align == 2'd0 && m_q.size() == 64) ||
                  (cfg_align == 2'd1 && m_post == 32)))
            m_ph = 3;
    endtask

    task automatic cyc(input logic a, input logic v, input logic [15:0] ad,
                       input logic [15:0] dt, input logic cof, input logic fr,
                       input logic op, input logic [3:0] tr);
        logic [31:0] e0;
        @(negedge clk);
        arm = a; bus_valid = v; bus_addr = ad; bus_data = dt;
        bus_cof = cof; bus_free = fr; bus_opfetch = op; trig = tr; rd_idx = 6'd0;
        model_step(a, v, ad, dt, cof, fr, op, tr);
        @(posedge clk);
        #1;
        chk({25'd0, count}, m_q.size(), "R11 count");
        chk({31'd0, done}, (m_ph == 3) ? 1 : 0, {cur_tag, " done"});
        e0 = (m_ph == 3 && m_q.size() > 0) ? m_q[0] : 32'h0;
        chk(rd_data, e0, "R12 read idx0");
    endtask

    task automatic do_arm();
        cyc(1'b1, 1'b1, 16'h1234, 16'h5678, 1'b1, 1'b0, 1'b0, 4'hF);
        chk({25'd0, count}, 32'd0, "R2 count cleared");
        chk({31'd0, done}, 32'd0, "R2 done cleared");
    endtask

    task automatic rnd(input int n, input logic [15:0] amask, input int tpct);
        for (int i = 0; i < n; i++) begin
            logic [3:0] tr;
            tr = ($urandom_range(99) < tpct) ? 4'($urandom_range(15)) : 4'h0;
            cyc(1'b0, $urandom_range(3) != 0, 16'($urandom) & amask, 16'($urandom),
                1'($urandom_range(1)), $urandom_range(3) == 0,
                $urandom_range(3) == 0, tr);
        end
    endtask

    task automatic check_buf(input string tag);
        for (int i = 0; i < 64; i++) begin
            logic [31:0] e;
            @(negedge clk);
            rd_idx = 6'(i);
            #1;
            e = (m_ph == 3 && i < m_q.size()) ? m_q[i] : 32'h0;
            chk(rd_data, e, tag);
        end
        @(negedge clk);
        rd_idx = 6'd0;
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        chk({25'd0, count}, 0, "R1 count");
        chk({31'd0, done}, 0, "R1 done");
        chk(rd_data, 0, "R1 rd_data");
        @(negedge clk);
        rst_n = 1'b1;

        // Flow mode, end alignment, directed sequencer walk
        cfg_mode = 2'd0; cfg_align = 2'd2; cfg_seq_tbl = 12'hED4; cur_tag = "R9";
        do_arm();
        rnd(12, 16'hFFFF, 0);
        cyc(1'b0, 1'b1, 16'h0100, 16'h0001, 1'b1, 1'b0, 1'b0, 4'b0010);
        rnd(5, 16'hFFFF, 0);
        chk({31'd0, done}, 0, "R3 unselected trigger ignored");
        cyc(1'b0, 1'b1, 16'h0200, 16'h0002, 1'b1, 1'b0, 1'b0, 4'b0001);
        cyc(1'b0, 1'b1, 16'h0300, 16'h0003, 1'b1, 1'b0, 1'b0, 4'b0010);
        chk({31'd0, done}, 1, "R9 done at trigger");
        check_buf("R4 R9 R12 flow/end readout");
        rnd(30, 16'hFFFF, 50);
        chk({31'd0, done}, 1, "R13 done held");
        check_buf("R13 contents frozen");

        // Loop mode, begin alignment, heavy address repetition
        cfg_mode = 2'd1; cfg_align = 2'd0; cur_tag = "R8";
        do_arm();
        rnd(800, 16'h0003, 10);
        chk({31'd0, done}, 1, "R8 begin done");
        chk({25'd0, count}, 64, "R8 begin full");
        check_buf("R5 R8 loop/begin readout");

        // Re-arm during capture
        cfg_mode = 2'd0; cfg_align = 2'd2;
        do_arm();
        rnd(30, 16'hFFFF, 0);
        do_arm();

        // Detail mode, mid alignment, wrap before trigger
        cfg_mode = 2'd2; cfg_align = 2'd1; cfg_seq_tbl = 12'hEDF; cur_tag = "R10";
        do_arm();
        rnd(200, 16'hFFFF, 0);
        chk({25'd0, count}, 64, "R11 saturated");
        cyc(1'b0, 1'b1, 16'hAAAA, 16'h5555, 1'b0, 1'b0, 1'b0, 4'b1000);
        rnd(150, 16'hFFFF, 0);
        chk({31'd0, done}, 1, "R10 mid done");
        check_buf("R6 R10 R11 detail/mid readout");

        // Off mode
        cfg_mode = 2'd3; cfg_align = 2'd2; cur_tag = "R9";
        do_arm();
        rnd(40, 16'hFFFF, 0);
        chk({25'd0, count}, 0, "R7 nothing stored");
        cyc(1'b0, 1'b1, 16'h0, 16'h0, 1'b1, 1'b0, 1'b0, 4'b1000);
        check_buf("R7 R12 empty buffer");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule